// File: doc/BRIEF.md
# Cycle-Stealing Dual Event Timer/Counter

This block holds two 12-bit up-counters that never advance on their own. Each channel watches a count source. In event mode the source is an external pin. In timer mode it is one of four internal prescaler taps. Every rising edge of the selected source raises a count request. A request is turned into an increment only by borrowing one whole instruction cycle from the processor. The processor marks the end of each instruction cycle with `cycStrobe`. At that boundary a pending request is granted: the counter advances, and `stall` stays high for the whole of the following instruction cycle. While `stall` is high the processor holds its next instruction and takes no interrupts.

Channel 1 always wins when both channels are waiting at the same boundary. The channel that loses is granted at the next boundary, so the two stolen cycles run back to back. A counter that wraps from all ones to zero sets a sticky overflow flag, which drives that channel's interrupt output. Software sets up each channel through a small write port. Each channel has a command register (mode, tap select, flag clear) and a direct count load.

Write select `wrSel` is `{isLoad, channel}`, where channel 0 is channel 1. Command data fields: bits [1:0] mode (00 stop, 01 event, 10 timer, 11 treated as stop), bits [3:2] tap index, bit 4 write-1-to-clear the overflow flag.

Top module: `dual_steal_counter`

## Requirements
- R1: After reset both counts read 0, both overflow flags are 0, `stall` is 0, and both channels are stopped.
- R2: In event mode (mode 01), each rising edge of the channel's `evtPin` bit (after a two-flop synchronizer) adds exactly one to that channel's count, provided edges are at least 32 clocks apart.
- R3: In timer mode (mode 10), the channel counts rising edges of `tapBus[rate]` only, where rate is command bits [3:2]. Edges on the other taps have no effect.
- R4: After a command write, counting starts only with the first rising edge seen after the selected source has been low. A source already high when the command is written is not counted.
- R5: When both channels have a pending request at the same `cycStrobe`, channel 1 is incremented at that boundary and channel 2 exactly one instruction cycle later.
- R6: Each channel holds at most one pending request. Extra edges that arrive while a request is still pending are lost.
- R7: An increment from 0xFFF gives 0x000 and sets that channel's `irq` bit. Counting continues after the wrap.
- R8: Writing a command with bit 4 set clears that channel's `irq`. Writing with bit 4 clear leaves `irq` unchanged.
- R9: A command write with mode 00 stops the channel and drops its pending request. The count is kept, and later edges are ignored.
- R10: A write with `wrSel` = {1, channel} loads `wrData` into that channel's count.
- R11: Each granted increment raises `stall` from the `cycStrobe` edge that grants it until the next `cycStrobe` edge. `stall` changes only at `cycStrobe` edges, so the total stalled clocks equal the instruction-cycle length times the number of increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrSel | input | 2 | {isLoad, channel} write target |
| wrData | input | 12 | Write data (command fields or count value) |
| evtPin | input | 2 | External event inputs, one per channel, asynchronous |
| tapBus | input | 4 | Internal prescaler pulse taps |
| cycStrobe | input | 1 | One-clock pulse on the last clock of each instruction cycle |
| stall | output | 1 | High during a stolen instruction cycle; holds off instructions and interrupts |
| irq | output | 2 | Sticky overflow flags, one per channel |
| countBus | output | 24 | Both counts; channel 1 in bits [11:0] |

## Verification
The assertions assume that `cycStrobe` is a single-clock pulse that recurs at a steady interval, and that it keeps arriving whenever a request is pending. If it stopped while `stall` was high, the stolen cycle would never end. They also assume that count edges are spaced widely enough for one grant to finish before the next edge arrives. The stimulus keeps to this by using a four-clock instruction cycle and pin edges no closer than 32 clocks. It gates the strobe off only while `stall` is low, and uses that gap to pile up surplus edges on purpose.

// File: rtl/steal_tc_pkg.sv
package steal_tc_pkg;

  typedef enum logic [1:0] {
    MODE_STOP  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_RSVD  = 2'b11
  } tcMode_e;

  localparam int MODE_LSB = 0;
  localparam int RATE_LSB = 2;
  localparam int CLR_BIT  = 4;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic inc;
    logic load;
    logic clrFlag;
  } chStrobe_t;

endpackage

// File: rtl/steal_tc_ctrl.sv
module steal_tc_ctrl
  import steal_tc_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int DATA_W      = 12,
  parameter int NTAP        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(NCH) + 1,
  parameter int RATE_W      = $clog2(NTAP)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [SEL_W-1:0]     wrSel,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NCH-1:0]       evtPin,
  input  logic [NTAP-1:0]      tapBus,
  input  logic                 cycStrobe,
  output logic                 stall,
  output chStrobe_t [NCH-1:0]  strb
);

  localparam int CH_W = SEL_W - 1;

  logic [SYNC_STAGES-1:0] syncQ [NCH];
  tcMode_e                modeQ [NCH];
  logic [RATE_W-1:0]      rateQ [NCH];
  logic [NCH-1:0] srcLvl, prevLvl, armed, pending, running, cntEdge;
  logic [NCH-1:0] cmdWr, ldWr, grant;
  logic           stealQ;

  // Fixed priority: lowest channel index wins at a strobe
  always_comb begin
    grant = '0;
    if (cycStrobe) begin
      for (int k = NCH - 1; k >= 0; k--) begin
        if (pending[k]) begin
          grant    = '0;
          grant[k] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          stealQ <= 1'b0;
    else if (cycStrobe) stealQ <= |pending;
  end

  assign stall = stealQ;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cmdWr[i] = wrEn && !wrSel[SEL_W-1] && (wrSel[CH_W-1:0] == CH_W'(i));
    assign ldWr[i]  = wrEn &&  wrSel[SEL_W-1] && (wrSel[CH_W-1:0] == CH_W'(i));

    assign running[i] = (modeQ[i] == MODE_EVENT) || (modeQ[i] == MODE_TIMER);
    assign srcLvl[i]  = (modeQ[i] == MODE_EVENT) ? syncQ[i][SYNC_STAGES-1]
                                                 : tapBus[rateQ[i]];
    assign cntEdge[i] = running[i] && armed[i] && srcLvl[i] && !prevLvl[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ[i]   <= '0;
        modeQ[i]   <= MODE_STOP;
        rateQ[i]   <= '0;
        prevLvl[i] <= 1'b0;
        armed[i]   <= 1'b0;
        pending[i] <= 1'b0;
      end else begin
        syncQ[i]   <= {syncQ[i][SYNC_STAGES-2:0], evtPin[i]};
        prevLvl[i] <= srcLvl[i];
        if (cmdWr[i]) begin
          modeQ[i]   <= tcMode_e'(wrData[MODE_LSB +: 2]);
          rateQ[i]   <= wrData[RATE_LSB +: RATE_W];
          armed[i]   <= 1'b0;
          pending[i] <= 1'b0;
        end else begin
          if (!srcLvl[i]) armed[i] <= 1'b1;
          pending[i] <= cntEdge[i] | (pending[i] & ~grant[i]);
        end
      end
    end

    assign strb[i].inc     = grant[i];
    assign strb[i].load    = ldWr[i];
    assign strb[i].clrFlag = cmdWr[i] && wrData[CLR_BIT];

    // R9: a stopped channel never holds a request
    assert_stop_no_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
      !running[i] |=> !pending[i]);

    if (i > 0) begin : g_pri
      // R5: a higher channel is granted only when no lower one waits
      assert_priority_R5: assert property (@(posedge clk) disable iff (!rstN)
        grant[i] |-> !(|pending[i-1:0]));
    end
  end

  // R5: at most one increment per boundary
  assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R11: a grant always opens a stolen cycle
  assert_grant_stalls_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |=> stall);

  // R11: stall edges line up with instruction boundaries
  assert_stall_rise_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(cycStrobe));
  assert_stall_fall_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> $past(cycStrobe));

endmodule

// File: rtl/steal_tc_dpath.sv
module steal_tc_dpath
  import steal_tc_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  chStrobe_t [NCH-1:0]   strb,
  input  logic [CNT_W-1:0]      loadData,
  output logic [NCH*CNT_W-1:0]  countBus,
  output logic [NCH-1:0]        irq
);

  logic [CNT_W-1:0] cntQ [NCH];
  logic [NCH-1:0]   flagQ, wrapHit;

  for (genvar i = 0; i < NCH; i++) begin : g_cnt
    assign wrapHit[i] = strb[i].inc && !strb[i].load && (cntQ[i] == '1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ[i]  <= '0;
        flagQ[i] <= 1'b0;
      end else begin
        if (strb[i].load)     cntQ[i] <= loadData;
        else if (strb[i].inc) cntQ[i] <= cntQ[i] + 1'b1;

        if (wrapHit[i])            flagQ[i] <= 1'b1;
        else if (strb[i].clrFlag)  flagQ[i] <= 1'b0;
      end
    end

    assign countBus[i*CNT_W +: CNT_W] = cntQ[i];
    assign irq[i] = flagQ[i];

    // R7: wrap lands on zero with the flag raised
    assert_wrap_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
      (strb[i].inc && !strb[i].load && cntQ[i] == '1) |=> (flagQ[i] && cntQ[i] == '0));

    // R7: the flag only rises from a wrap
    assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[i]) |-> $past(strb[i].inc && cntQ[i] == '1));

    // R8: clearing without a coincident wrap leaves the flag low
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strb[i].clrFlag && !wrapHit[i]) |=> !flagQ[i]);

    // R2: the count moves only on a grant or a load
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!strb[i].inc && !strb[i].load) |=> $stable(cntQ[i]));
  end

endmodule

// File: rtl/dual_steal_counter.sv
module dual_steal_counter
  import steal_tc_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int CNT_W       = 12,
  parameter int NTAP        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [$clog2(NCH):0]     wrSel,
  input  logic [CNT_W-1:0]         wrData,
  input  logic [NCH-1:0]           evtPin,
  input  logic [NTAP-1:0]          tapBus,
  input  logic                     cycStrobe,
  output logic                     stall,
  output logic [NCH-1:0]           irq,
  output logic [NCH*CNT_W-1:0]     countBus
);

  localparam int SEL_W  = $clog2(NCH) + 1;
  localparam int RATE_W = $clog2(NTAP);

  chStrobe_t [NCH-1:0] strb;

  steal_tc_ctrl #(
    .NCH(NCH), .DATA_W(CNT_W), .NTAP(NTAP), .SYNC_STAGES(SYNC_STAGES),
    .SEL_W(SEL_W), .RATE_W(RATE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .evtPin(evtPin), .tapBus(tapBus), .cycStrobe(cycStrobe),
    .stall(stall), .strb(strb)
  );

  steal_tc_dpath #(.NCH(NCH), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .loadData(wrData),
    .countBus(countBus), .irq(irq)
  );

endmodule

// File: tb/sim_dual_steal_counter.sv
module sim_dual_steal_counter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [11:0] wrData = '0;
  logic [1:0]  evtPin = '0;
  logic [3:0]  tapBus = '0;
  logic        cycStrobe = 1'b0;
  logic        stall;
  logic [1:0]  irq;
  logic [23:0] countBus;

  int vectors = 0, miscompares = 0;
  int stallClocks = 0, cyc = 0, phase = 0;
  int incTime [2];
  logic [11:0] lastCnt [2];
  bit strobeOn = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  dual_steal_counter u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .evtPin(evtPin), .tapBus(tapBus), .cycStrobe(cycStrobe),
    .stall(stall), .irq(irq), .countBus(countBus)
  );

  function automatic logic [11:0] getCnt(int ch);
    return countBus[ch*12 +: 12];
  endfunction

  // Instruction cycle of four clocks
  initial begin
    forever begin
      @(negedge clk);
      phase = (phase + 1) % 4;
      cycStrobe = strobeOn && (phase == 3);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (stall === 1'b1) stallClocks++;
    for (int ch = 0; ch < 2; ch++) begin
      if (getCnt(ch) !== lastCnt[ch]) begin
        incTime[ch] = cyc;
        lastCnt[ch] = getCnt(ch);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [11:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulsePins(logic [1:0] mask, int n);
    for (int k = 0; k < n; k++) begin
      evtPin = evtPin | mask;  waitClk(16);
      evtPin = evtPin & ~mask; waitClk(16);
    end
  endtask

  task automatic pulseTap(int idx);
    tapBus[idx] = 1'b1; waitClk(16);
    tapBus[idx] = 1'b0; waitClk(16);
  endtask

  task automatic testReset();
    check("R1 count ch1", getCnt(0), 0);
    check("R1 count ch2", getCnt(1), 0);
    check("R1 irq", irq, 0);
    check("R1 stall", stall, 0);
  endtask

  task automatic testEvent();
    wr(2'b00, 12'h001);
    stallClocks = 0;
    pulsePins(2'b01, 3);
    waitClk(40);
    check("R2 ch1 count", getCnt(0), 3);
    check("R2 ch2 untouched", getCnt(1), 0);
    check("R11 stall clocks", stallClocks, 12);
  endtask

  task automatic testArm();
    evtPin[1] = 1'b1; waitClk(10);
    wr(2'b01, 12'h001);
    waitClk(30);
    check("R4 high at write", getCnt(1), 0);
    evtPin[1] = 1'b0; waitClk(16);
    evtPin[1] = 1'b1; waitClk(40);
    check("R4 first edge", getCnt(1), 1);
    evtPin[1] = 1'b0; waitClk(16);
  endtask

  task automatic testTimer();
    wr(2'b00, 12'h00A);   // timer, tap 2
    wr(2'b10, 12'h000);
    for (int k = 0; k < 5; k++) begin
      pulseTap(1);
      pulseTap(2);
    end
    pulseTap(0); pulseTap(3);
    waitClk(20);
    check("R3 tap 2 edges", getCnt(0), 5);
    wr(2'b11, 12'h123);
    waitClk(2);
    check("R10 load ch2", getCnt(1), 12'h123);
  endtask

  task automatic testSinglePending();
    wr(2'b00, 12'h001);
    wr(2'b10, 12'h000);
    waitClk(8);
    strobeOn = 1'b0;
    stallClocks = 0;
    pulsePins(2'b01, 3);
    check("R6 no service yet", getCnt(0), 0);
    check("R6 no stall", stall, 0);
    strobeOn = 1'b1;
    waitClk(20);
    check("R6 one increment", getCnt(0), 1);
    check("R6 one steal", stallClocks, 4);
  endtask

  task automatic testArbitration();
    wr(2'b10, 12'h000);
    wr(2'b11, 12'h000);
    waitClk(4);
    stallClocks = 0;
    pulsePins(2'b11, 1);
    waitClk(30);
    check("R5 ch1 count", getCnt(0), 1);
    check("R5 ch2 count", getCnt(1), 1);
    check("R5 ch2 one cycle after ch1", incTime[1] - incTime[0], 4);
    check("R11 back-to-back stall", stallClocks, 8);
  endtask

  task automatic testStop();
    wr(2'b10, 12'h055);
    waitClk(8);
    strobeOn = 1'b0;
    pulsePins(2'b01, 1);
    wr(2'b00, 12'h000);
    stallClocks = 0;
    strobeOn = 1'b1;
    pulsePins(2'b01, 2);
    waitClk(30);
    check("R9 count kept", getCnt(0), 12'h055);
    check("R9 no steal", stallClocks, 0);
  endtask

  task automatic testMaxRate();
    int n = 40;
    int st1 = 12'hFF0, st2 = 12'h7C0;
    wr(2'b00, 12'h011);
    wr(2'b01, 12'h011);
    wr(2'b10, 12'(st1));
    wr(2'b11, 12'(st2));
    waitClk(4);
    stallClocks = 0;
    pulsePins(2'b11, n);
    waitClk(40);
    check("R7 ch1 wrapped count", getCnt(0), (st1 + n) & 12'hFFF);
    check("R7 ch2 count", getCnt(1), (st2 + n) & 12'hFFF);
    check("R7 ch1 flag", irq[0], (st1 + n) > 12'hFFF);
    check("R7 ch2 flag", irq[1], (st2 + n) > 12'hFFF);
    check("R11 max rate stall", stallClocks, 4 * 2 * n);
    wr(2'b00, 12'h001);
    waitClk(2);
    check("R8 flag kept", irq[0], 1);
    wr(2'b00, 12'h011);
    waitClk(2);
    check("R8 flag cleared", irq[0], 0);
    check("R8 count kept", getCnt(0), (st1 + n) & 12'hFFF);
  endtask

  initial begin
    incTime[0] = 0; incTime[1] = 0;
    lastCnt[0] = '0; lastCnt[1] = '0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    testReset();
    strobeOn = 1'b1;
    testEvent();
    testArm();
    testTimer();
    testSinglePending();
    testArbitration();
    testStop();
    testMaxRate();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule